// File: doc/BRIEF.md
# Selectable-Topology Prefix Adder

A purely combinational binary adder of parameterised width that adds two unsigned operands and a carry-in. It returns the sum and the carry-out. Each bit first forms a generate term (both operand bits set) and a propagate term (the operand bits differ). Carries are then resolved by a prefix network built from combine cells. A combine cell merges a higher (generate, propagate) pair with a lower one into a group generate and, where a later level still needs it, a group propagate. Each sum bit is the bit's propagate XOR the carry entering that bit.

A compile-time parameter chooses the carry network, and the interface is the same for every choice:
- Encoding 0 is a dense log-depth tree that resolves the carry of every bit.
- Encoding 1 is a sparse tree of the same shape that works on 4-bit blocks and resolves only block-boundary carries.
- Encoding 2 is a spanning arrangement over the same 4-bit blocks: a reduce-then-distribute tree.

In both grouped forms, each block finishes with a short ripple fed by its boundary carry. The carry-in is folded into bit 0's generate term, so every resolved prefix already includes it. A designer picks the network that best fits the area and depth budget of the surrounding datapath.

Top module: `prefix_adder`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals a + b + cin as an unsigned (W+1)-bit value, for each network choice.
- R2: The carry into bit 0 is cin, so sum[0] equals a[0] XOR b[0] XOR cin.
- R3: When a XOR b is all ones, the carry passes straight through the whole word: sum is all ones when cin is 0, and sum is 0 with cout equal to 1 when cin is 1.
- R4: When no bit position has both operand bits set and cin is 0, sum equals a OR b and cout is 0.
- R5: Parameter TOPO selects the network: 0 is the dense per-bit tree, 1 is the sparse 4-bit-block tree, and 2 is the spanning reduce-then-distribute block tree. All three give identical outputs for identical inputs.
- R6: Parameter W is a power of two and at least 4, with 16 as the default. The grouped networks split the word into W/4 blocks of 4 bits.
- R7: At W = 16 with cin = 0, the following hold: 0x72AD + 0x1AAA gives sum 0x8D57 and cout 0; 0x57D5 + 0x6B55 gives sum 0xC32A and cout 0; 0x50E4 + 0x4D49 gives sum 0x9E2D and cout 0.
- R8: A carry that starts at bit 0 travels across the full width. All ones plus 0 with cin = 1 gives sum 0 and cout 1. All ones plus 1 with cin = 0 gives sum 0 and cout 1.
- R9: All-zero operands with cin = 0 give sum 0 and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of a + b + cin |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The bench aims at carries that must cross block boundaries and the whole word. A grouped network that feeds a block the wrong boundary carry would corrupt exactly the upper bits of that block. The bench also targets the all-propagate case. A tree that drops the carry-in from its prefix terms gives a correct low bit but a wrong cout and wrong upper bits there. The alternating patterns and the known vectors catch a miswired lower index in a combine cell, which corrupts only some bit positions. Random operands at 16 and 64 bits run through all three networks against the arithmetic sum, so a flaw that appears only in a deeper tree is exposed.

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int W    = 16,
  parameter int TOPO = 0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LV = $clog2(W);
  localparam int M  = W / 4;
  localparam int LM = (M > 1) ? $clog2(M) : 0;
  localparam int NL = (LM > 0) ? 2 * LM - 1 : 0;

  logic [W-1:0] g, p, gf;
  logic [W:0]   c;

  assign g   = a & b;
  assign p   = a ^ b;
  assign gf  = {g[W-1:1], g[0] | (p[0] & cin)};
  assign c[0] = cin;
  assign sum  = p ^ c[W-1:0];
  assign cout = c[W];

  generate
    if (W < 4 || (W & (W - 1)) != 0 || TOPO < 0 || TOPO > 2) begin : g_bad
      $error("prefix_adder: W must be a power of two >= 4 and TOPO in 0..2");
    end

    if (TOPO == 0) begin : g_dense
      logic [W-1:0] kg [0:LV];
      logic [W-1:0] kp [0:LV];
      logic         unused_kp;
      assign kg[0] = gf;
      assign kp[0] = p;
      assign unused_kp = ^kp[LV];
      for (genvar k = 0; k < LV; k++) begin : g_lvl
        localparam int D = 1 << k;
        for (genvar i = 0; i < W; i++) begin : g_bit
          if (i >= 2 * D) begin : g_black
            assign kg[k+1][i] = kg[k][i] | (kp[k][i] & kg[k][i-D]);
            assign kp[k+1][i] = kp[k][i] & kp[k][i-D];
          end else if (i >= D) begin : g_grey
            assign kg[k+1][i] = kg[k][i] | (kp[k][i] & kg[k][i-D]);
            assign kp[k+1][i] = kp[k][i];
          end else begin : g_buf
            assign kg[k+1][i] = kg[k][i];
            assign kp[k+1][i] = kp[k][i];
          end
        end
      end
      for (genvar i = 0; i < W; i++) begin : g_carry
        assign c[i+1] = kg[LV][i];
      end
    end else begin : g_grouped
      logic [M-1:0] bg, bp, pg;
      for (genvar j = 0; j < M; j++) begin : g_blk
        assign bg[j] = gf[4*j+3] | (p[4*j+3] & (gf[4*j+2] | (p[4*j+2] &
                       (gf[4*j+1] | (p[4*j+1] & gf[4*j])))));
        assign bp[j] = &p[4*j +: 4];
      end

      if (TOPO == 1) begin : g_sparse
        logic [M-1:0] sg [0:LM];
        logic [M-1:0] sp [0:LM];
        logic         unused_sp;
        assign sg[0] = bg;
        assign sp[0] = bp;
        assign unused_sp = ^sp[LM];
        for (genvar k = 0; k < LM; k++) begin : g_lvl
          localparam int D = 1 << k;
          for (genvar i = 0; i < M; i++) begin : g_node
            if (i >= D) begin : g_cell
              assign sg[k+1][i] = sg[k][i] | (sp[k][i] & sg[k][i-D]);
              assign sp[k+1][i] = sp[k][i] & sp[k][i-D];
            end else begin : g_buf
              assign sg[k+1][i] = sg[k][i];
              assign sp[k+1][i] = sp[k][i];
            end
          end
        end
        assign pg = sg[LM];
      end else begin : g_span
        logic [M-1:0] tg [0:NL];
        logic [M-1:0] tp [0:NL];
        logic         unused_tp;
        assign tg[0] = bg;
        assign tp[0] = bp;
        assign unused_tp = ^tp[NL];
        for (genvar s = 0; s < NL; s++) begin : g_lvl
          localparam bit UP = (s < LM);
          localparam int D  = UP ? (1 << s) : (1 << (2 * LM - 2 - s));
          for (genvar i = 0; i < M; i++) begin : g_node
            if (UP ? ((i + 1) % (2 * D) == 0)
                   : (((i + 1) % (2 * D) == D) && (i + 1 > 2 * D))) begin : g_cell
              assign tg[s+1][i] = tg[s][i] | (tp[s][i] & tg[s][i-D]);
              assign tp[s+1][i] = tp[s][i] & tp[s][i-D];
            end else begin : g_buf
              assign tg[s+1][i] = tg[s][i];
              assign tp[s+1][i] = tp[s][i];
            end
          end
        end
        assign pg = tg[NL];
      end

      for (genvar j = 0; j < M; j++) begin : g_rip
        assign c[4*j+4] = pg[j];
        for (genvar k = 0; k < 3; k++) begin : g_fa
          assign c[4*j+k+1] = g[4*j+k] | (p[4*j+k] & c[4*j+k]);
        end
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      a_r1_sum_exact: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("R1: {cout,sum} differs from a+b+cin");
      a_r2_bit0_carry: assert (sum[0] == (a[0] ^ b[0] ^ cin))
        else $error("R2: bit 0 does not see cin");
      if (&(a ^ b)) begin
        a_r3_pass_through: assert (cout == cin && sum == {W{~cin}})
          else $error("R3: all-propagate word mishandled");
      end
      if ((a & b) == '0 && !cin) begin
        a_r4_no_generate: assert (sum == (a | b) && !cout)
          else $error("R4: carry appeared without any generate");
      end
    end
  end
endmodule

// File: tb/sim_prefix_adder.sv
module sim_prefix_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int errs = 0;
  int checks = 0;

  logic [15:0] a16 = '0, b16 = '0;
  logic        c16 = 1'b0;
  logic [15:0] s16 [0:2];
  logic        co16 [0:2];

  logic [63:0] a64 = '0, b64 = '0;
  logic        c64 = 1'b0;
  logic [63:0] s64 [0:2];
  logic        co64 [0:2];

  prefix_adder #(.W(16), .TOPO(0)) u0 (.a(a16), .b(b16), .cin(c16), .sum(s16[0]), .cout(co16[0]));
  prefix_adder #(.W(16), .TOPO(1)) u1 (.a(a16), .b(b16), .cin(c16), .sum(s16[1]), .cout(co16[1]));
  prefix_adder #(.W(16), .TOPO(2)) u2 (.a(a16), .b(b16), .cin(c16), .sum(s16[2]), .cout(co16[2]));
  prefix_adder #(.W(64), .TOPO(0)) u3 (.a(a64), .b(b64), .cin(c64), .sum(s64[0]), .cout(co64[0]));
  prefix_adder #(.W(64), .TOPO(1)) u4 (.a(a64), .b(b64), .cin(c64), .sum(s64[1]), .cout(co64[1]));
  prefix_adder #(.W(64), .TOPO(2)) u5 (.a(a64), .b(b64), .cin(c64), .sum(s64[2]), .cout(co64[2]));

  function automatic logic [16:0] ref16(logic [15:0] x, logic [15:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {16'd0, ci};
  endfunction

  function automatic logic [64:0] ref64(logic [63:0] x, logic [63:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {64'd0, ci};
  endfunction

  task automatic run16(logic [15:0] x, logic [15:0] y, logic ci, string req);
    logic [16:0] e;
    @(posedge clk);
    a16 = x; b16 = y; c16 = ci;
    @(negedge clk);
    e = ref16(x, y, ci);
    for (int t = 0; t < 3; t++) begin
      checks++;
      if ({co16[t], s16[t]} !== e) begin
        errs++;
        $display("FAIL %s W=16 topo=%0d a=%h b=%h cin=%b got %h exp %h",
                 req, t, x, y, ci, {co16[t], s16[t]}, e);
      end
    end
  endtask

  task automatic run64(logic [63:0] x, logic [63:0] y, logic ci, string req);
    logic [64:0] e;
    @(posedge clk);
    a64 = x; b64 = y; c64 = ci;
    @(negedge clk);
    e = ref64(x, y, ci);
    for (int t = 0; t < 3; t++) begin
      checks++;
      if ({co64[t], s64[t]} !== e) begin
        errs++;
        $display("FAIL %s W=64 topo=%0d a=%h b=%h cin=%b got %h exp %h",
                 req, t, x, y, ci, {co64[t], s64[t]}, e);
      end
    end
  endtask

  task automatic fixed16(logic [15:0] x, logic [15:0] y, logic ci,
                         logic [15:0] es, logic eco, string req);
    @(posedge clk);
    a16 = x; b16 = y; c16 = ci;
    @(negedge clk);
    for (int t = 0; t < 3; t++) begin
      checks++;
      if (s16[t] !== es || co16[t] !== eco) begin
        errs++;
        $display("FAIL %s topo=%0d got sum=%h cout=%b exp sum=%h cout=%b",
                 req, t, s16[t], co16[t], es, eco);
      end
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed1234);
    // R9: all-zero state
    fixed16(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R9");
    run64(64'd0, 64'd0, 1'b0, "R9");
    // R7: known vectors
    fixed16(16'h72AD, 16'h1AAA, 1'b0, 16'h8D57, 1'b0, "R7");
    fixed16(16'h57D5, 16'h6B55, 1'b0, 16'hC32A, 1'b0, "R7");
    fixed16(16'h50E4, 16'h4D49, 1'b0, 16'h9E2D, 1'b0, "R7");
    // R8: carry from bit 0 across the word
    fixed16(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R8");
    fixed16(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, "R8");
    run64({64{1'b1}}, 64'd0, 1'b1, "R8");
    run64({64{1'b1}}, 64'd1, 1'b0, "R8");
    // R3: all-propagate words, both carry-in values
    fixed16(16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, "R3");
    fixed16(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, "R3");
    fixed16(16'hF0F0, 16'h0F0F, 1'b1, 16'h0000, 1'b1, "R3");
    run64({32{2'b10}}, {32{2'b01}}, 1'b1, "R3");
    // R4: no generate anywhere
    fixed16(16'hA0A0, 16'h0505, 1'b0, 16'hA5A5, 1'b0, "R4");
    run64({16{4'h8}}, {16{4'h3}}, 1'b0, "R4");
    // R2: carry-in lands on bit 0
    fixed16(16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, "R2");
    fixed16(16'h0001, 16'h0000, 1'b1, 16'h0002, 1'b0, "R2");
    // R6: block-boundary carries
    fixed16(16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, "R6");
    fixed16(16'h0FFF, 16'h0000, 1'b1, 16'h1000, 1'b0, "R6");
    fixed16(16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, "R6");
    // R1 / R5: random operands across all networks
    for (int n = 0; n < 3000; n++) begin
      run16(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    end
    for (int n = 0; n < 3000; n++) begin
      run64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R5");
    end
    for (int n = 0; n < 64; n++) begin
      run64(64'd1 << n, ~(64'd1 << n), 1'b1, "R1");
    end
    summary();
    $finish;
  end
endmodule